// File: doc/BRIEF.md
# Ramped Stereo Digital Attenuator

This block scales a stereo stream of signed PCM samples by one gain shared by both channels. The gain is selected by a 7-bit attenuation code that a control register drives steadily onto the block. The block never jumps to a new gain. It holds the applied gain as a linear level and moves that level one count per accepted sample toward the level the code asks for, so volume changes glide and do not click.

Every input sample pair is qualified by a valid strobe. Each accepted pair is multiplied by the level in force before that strobe's step, rounded back to the input width, and presented one clock later with a matching valid strobe. Code 0 is a true mute. The top code is exact unity gain. Out of reset the level is zero, so the stream starts silent and fades up to whatever code is applied.

Top module: `att_ramp_stereo`

## Requirements
- R1: The target level for code c is c*8 for c from 1 to 126, 0 for c = 0, and 1024 (full scale) for c = 127. The target is read from the code input on every accepted sample.
- R2: On each clock with valid_i high, the applied level moves exactly one count toward the target, or stays put when it equals the target. On a clock with valid_i low the level does not change.
- R3: For an accepted sample x, the output is floor((x*L + 512) / 1024), where L is the applied level before that strobe's step. Both channels use the same L.
- R4: At level 1024 each output equals its input sample exactly, including -32768 and 32767.
- R5: At level 0 both outputs are exactly 0 for any input.
- R6: valid_o is high exactly one clock after each clock with valid_i high, and low otherwise.
- R7: While reset is asserted and after it is released, valid_o is 0, both outputs are 0, and the applied level is 0. The first accepted sample after reset therefore produces 0.
- R8: If the code changes while a ramp is under way, the ramp continues from the current applied level toward the new target, with no jump.
- R9: A full sweep from level 1024 down to 0 takes exactly 1024 accepted samples, and the same holds for a sweep up from 0 to 1024.
- R10: Between accepted samples, left_o and right_o hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample pair is valid |
| left_i | input | 16 | Left sample, signed two's complement |
| right_i | input | 16 | Right sample, signed two's complement |
| atten_code_i | input | 7 | Attenuation code, 0 = mute, 127 = unity |
| valid_o | output | 1 | Output sample pair is valid |
| left_o | output | 16 | Attenuated left sample |
| right_o | output | 16 | Attenuated right sample |

## Verification
The bench builds the block with its default 16-bit samples, 7-bit code and 10-bit level scale, which is small enough to run complete 1024-step sweeps up and down and to visit all 128 codes in turn. The left channel is fed the constant 1024, so under R3 its output equals the applied level, and the level trajectory can be read at the ports on every strobe. The right channel carries varied values and the extremes of the signed range, so the rounding, unity and mute cases are checked against arithmetic in the bench.

// File: rtl/att_pkg.sv
package att_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/att_gain_map.sv
module att_gain_map #(
  parameter int CODE_W  = 7,
  parameter int LEVEL_W = 10
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LEVEL_W:0]  level_o
);
  localparam int SHIFT = LEVEL_W - CODE_W;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [LEVEL_W:0] FULL = (LEVEL_W+1)'(1) << LEVEL_W;

  // linear map; top code is lifted to exact full scale
  always_comb begin
    if (code_i == CODE_MAX) level_o = FULL;
    else                    level_o = (LEVEL_W+1)'(code_i) << SHIFT;
  end
endmodule

// File: rtl/att_gain_ramp.sv
module att_gain_ramp
  import att_pkg::*;
#(
  parameter int LEVEL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [LEVEL_W:0] target_i,
  output logic [LEVEL_W:0] level_o
);
  logic [LEVEL_W:0] level_q;
  ramp_dir_e        dir;

  always_comb begin
    if (target_i > level_q)      dir = RAMP_UP;
    else if (target_i < level_q) dir = RAMP_DOWN;
    else                         dir = RAMP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (step_i) begin
      unique case (dir)
        RAMP_UP:   level_q <= level_q + 1'b1;
        RAMP_DOWN: level_q <= level_q - 1'b1;
        default:   level_q <= level_q;
      endcase
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/att_chan_scale.sv
module att_chan_scale #(
  parameter int DATA_W  = 16,
  parameter int LEVEL_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [LEVEL_W:0]  level_i,
  output logic [DATA_W-1:0] sample_o
);
  localparam int PROD_W = DATA_W + LEVEL_W + 2;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (LEVEL_W - 1);

  logic signed [PROD_W-1:0] a_ext, b_ext, prod, rnd;
  logic [DATA_W-1:0]        scaled;
  logic [DATA_W-1:0]        sample_q;

  always_comb begin
    a_ext  = $signed(sample_i);
    b_ext  = $signed({{(PROD_W-LEVEL_W-1){1'b0}}, level_i});
    prod   = a_ext * b_ext;
    rnd    = prod + HALF;
    scaled = rnd[LEVEL_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_q <= '0;
    else if (en_i)   sample_q <= (level_i == '0) ? '0 : scaled;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/att_ramp_stereo.sv
module att_ramp_stereo #(
  parameter int DATA_W  = 16,
  parameter int CODE_W  = 7,
  parameter int LEVEL_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [CODE_W-1:0] atten_code_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  localparam int NCH   = 2;
  localparam int LVL_W = LEVEL_W + 1;

  logic [LVL_W-1:0]             target_lvl;
  logic [LVL_W-1:0]             level_q;
  logic [NCH-1:0][DATA_W-1:0]   smp_in;
  logic [NCH-1:0][DATA_W-1:0]   smp_out;
  logic                         valid_q;

  att_gain_map #(.CODE_W(CODE_W), .LEVEL_W(LEVEL_W)) u_map (
    .code_i  (atten_code_i),
    .level_o (target_lvl)
  );

  att_gain_ramp #(.LEVEL_W(LEVEL_W)) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (valid_i),
    .target_i (target_lvl),
    .level_o  (level_q)
  );

  assign smp_in = {right_i, left_i};

  // multiply uses the level before this strobe's step
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    att_chan_scale #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_scale (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (valid_i),
      .sample_i (smp_in[ch]),
      .level_i  (level_q),
      .sample_o (smp_out[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;
  assign left_o  = smp_out[0];
  assign right_o = smp_out[1];
endmodule

// File: rtl/att_ramp_stereo_chk.sv
module att_ramp_stereo_chk #(
  parameter int DATA_W  = 16,
  parameter int LEVEL_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] left_i,
  input logic [DATA_W-1:0] right_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic [LEVEL_W:0]  level_q
);
  localparam int FULL = 1 << LEVEL_W;

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R6
  AST_LEVEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (int'(level_q) == int'($past(level_q)) + 1) ||
                (int'(level_q) == int'($past(level_q)) - 1) ||
                (level_q == $past(level_q))); // R2
  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(level_q)); // R2
  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_q) <= FULL); // R1
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(left_o) && $stable(right_o)); // R10
  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && level_q == '0) |=> (left_o == '0) && (right_o == '0)); // R5
  AST_UNITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && int'(level_q) == FULL) |=>
      (left_o == $past(left_i)) && (right_o == $past(right_i))); // R4
endmodule

bind att_ramp_stereo att_ramp_stereo_chk #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .left_i  (left_i),
  .right_i (right_i),
  .valid_o (valid_o),
  .left_o  (left_o),
  .right_o (right_o),
  .level_q (level_q)
);

// File: tb/att_ramp_stereo_bench.sv
`timescale 1ns/1ps
module att_ramp_stereo_bench;
  localparam int DATA_W  = 16;
  localparam int CODE_W  = 7;
  localparam int LEVEL_W = 10;
  localparam int FULL    = 1 << LEVEL_W;
  localparam int PROBE   = FULL; // left probe: output equals level

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [DATA_W-1:0] left_i = '0;
  logic [DATA_W-1:0] right_i = '0;
  logic [CODE_W-1:0] atten_code_i = 7'd127;
  logic              valid_o;
  logic [DATA_W-1:0] left_o;
  logic [DATA_W-1:0] right_o;

  int checks = 0;
  int errors = 0;
  int lvl    = 0;   // bench model of applied level
  int seed_n = 0;

  always #2.5 clk_i = ~clk_i;

  att_ramp_stereo #(.DATA_W(DATA_W), .CODE_W(CODE_W), .LEVEL_W(LEVEL_W)) u_att_ramp_stereo (
    .clk_i, .rst_ni, .valid_i, .left_i, .right_i, .atten_code_i,
    .valid_o, .left_o, .right_o
  );

  function automatic int tgt_of(int c);
    if (c == 127) return FULL;
    return c * 8;
  endfunction

  function automatic int scale(int x, int l);
    longint p;
    p = longint'(x) * longint'(l) + longint'(FULL / 2);
    return int'(p >>> LEVEL_W);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // one accepted sample; checks the output against the model
  task automatic send(int l, int r, string req);
    @(negedge clk_i);
    valid_i = 1'b1;
    left_i  = DATA_W'(l);
    right_i = DATA_W'(r);
    @(posedge clk_i); #1;
    check("R6", "valid_o", int'(valid_o), 1);
    check(req, "left_o",  int'($signed(left_o)),  scale(l, lvl));
    check(req, "right_o", int'($signed(right_o)), scale(r, lvl));
    if (tgt_of(int'(atten_code_i)) > lvl)      lvl++;
    else if (tgt_of(int'(atten_code_i)) < lvl) lvl--;
  endtask

  task automatic idle(int n, string req);
    logic [DATA_W-1:0] l0, r0;
    l0 = left_o; r0 = right_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      left_i  = DATA_W'(i * 777);
      right_i = DATA_W'(-i * 555);
      @(posedge clk_i); #1;
      check("R6", "valid_o idle", int'(valid_o), 0);
      check(req, "left_o hold",  int'(left_o),  int'(l0));
      check(req, "right_o hold", int'(right_o), int'(r0));
    end
  endtask

  function automatic int next_r();
    seed_n = (seed_n * 1103 + 12345) % 65536;
    return seed_n - 32768;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R7: reset state
    #12;
    check("R7", "valid_o in reset", int'(valid_o), 0);
    check("R7", "left_o in reset",  int'(left_o), 0);
    check("R7", "right_o in reset", int'(right_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R7", "valid_o after reset", int'(valid_o), 0);

    // R7, R9: first sample muted, full ramp up takes 1024 strobes
    send(PROBE, 20000, "R7");
    for (int i = 1; i < FULL; i++) send(PROBE, next_r(), "R3");
    send(PROBE, 1234, "R9");
    check("R9", "level after 1024 up strobes", int'($signed(left_o)), FULL);

    // R4: unity, including extremes
    send(PROBE, -32768, "R4");
    check("R4", "unity min", int'($signed(right_o)), -32768);
    send(PROBE, 32767, "R4");
    check("R4", "unity max", int'($signed(right_o)), 32767);
    for (int i = 0; i < 8; i++) begin
      int r = next_r();
      send(r, -r - 1, "R4");
      check("R4", "unity left", int'($signed(left_o)), r);
    end

    // R2, R10: code change without strobes moves nothing
    atten_code_i = 7'd0;
    idle(4, "R10");
    send(PROBE, 100, "R2");
    check("R2", "level unchanged over idle", int'($signed(left_o)), FULL);

    // R9: full sweep down, 1024 strobes to mute
    for (int i = 1; i < FULL - 1; i++) send(PROBE, next_r(), "R3");
    send(PROBE, 0, "R9");
    check("R9", "level one above mute", int'($signed(left_o)), 1);
    send(PROBE, 0, "R9");
    check("R9", "level after 1024 down strobes", int'($signed(left_o)), 0);
    // R5: mute gives zero for any input
    send(-32768, 32767, "R5");
    check("R5", "mute left", int'($signed(left_o)), 0);
    check("R5", "mute right", int'($signed(right_o)), 0);
    send(-1, 1, "R5");

    // R1: visit every code, settle, read level through probe
    for (int c = 0; c < 128; c++) begin
      atten_code_i = CODE_W'(c);
      while (lvl != tgt_of(c)) send(PROBE, next_r(), "R3");
      send(PROBE, next_r(), "R1");
      check("R1", $sformatf("settled level code %0d", c), int'($signed(left_o)), tgt_of(c));
    end

    // R8: retarget mid-ramp
    atten_code_i = 7'd64;
    while (lvl != 512) send(PROBE, next_r(), "R3");
    atten_code_i = 7'd127;
    for (int i = 0; i < 10; i++) send(PROBE, next_r(), "R8");
    atten_code_i = 7'd0;
    send(PROBE, 300, "R8");
    check("R8", "level at retarget", int'($signed(left_o)), 522);
    send(PROBE, 300, "R8");
    check("R8", "continues down from current", int'($signed(left_o)), 521);
    idle(2, "R10");
    send(PROBE, -300, "R8");
    check("R8", "resume after gap", int'($signed(left_o)), 520);

    // R3: rounding at a mid level, both channels same gain
    atten_code_i = 7'd40;
    while (lvl != 320) send(PROBE, next_r(), "R3");
    send(3, -3, "R3");
    send(-32768, 32767, "R3");
    check("R3", "mid level left", int'($signed(left_o)), scale(-32768, 320));
    check("R3", "mid level right", int'($signed(right_o)), scale(32767, 320));

    summary();
    $finish;
  end
endmodule